// File: doc/BRIEF.md
# Key Matrix Scanner with Snapshot Queue

This block scans a keyboard matrix of up to sixteen drive lines and eight sense lines. It drives one row at a time from a slow scan clock and checks that each sense line stays steady through that row's time slot. At the end of every full pass it packs the keys found into a snapshot of eight one-byte entries. The snapshot goes into a small queue that software drains through two 32-bit entry registers.

A status register shows how many snapshots are waiting. It also holds two sticky flags, one for "a pass found a key" and one for "queue depth reached the threshold". Writing 1 to a flag clears it. A level interrupt combines each flag with its enable. Software sets the per-row settle time, the threshold and the enables through one control register, and it can stop scanning at any time.

Top module: `keymatrix_scanner`

## Requirements
- R1: Each entry byte reads as {valid (bit 7), row (bits 6:3), column (bits 2:0)}. Keys are listed in ascending row order, then ascending column order. Entry 0 sits in bits 7:0 of the low entry register (offset 0x8), and entries 4..7 sit in the high entry register (offset 0xC).
- R2: Slots left unused by a snapshot read as zero. When more than eight keys are down, only the first eight in R1 order are kept.
- R3: Each row is driven alone, active high, for 16 plus the debounce count scan cycles. Exactly 5 idle cycles with no row driven come before row 0 of every pass.
- R4: A key is reported only if its sense line holds the same pressed level for every cycle of its row slot.
- R5: A pass that finds at least one key pushes one snapshot; a pass with no key pushes nothing. Status bits 7:4 give the number of queued snapshots. Reading the high entry register removes the head snapshot; reading the low entry register removes nothing.
- R6: A snapshot produced while the queue is full is dropped and the count stays at the depth. An empty queue reads as zero in both entry registers.
- R7: Status bit 0 is set by any pushed snapshot. Status bit 2 is set while the count is at least a non-zero threshold. Writing 1 to either bit clears it, but a condition that still holds sets it again.
- R8: The interrupt output is high when status bit 0 is set with control bit 1, or when status bit 2 is set with control bit 3.
- R9: While control bit 0 (enable) is clear, no row is driven and the queue keeps its contents.
- R10: Control register (offset 0x0) fields are: enable in bit 0, key-found interrupt enable in bit 1, threshold interrupt enable in bit 3, 10-bit debounce count in bits 13:4 (at most 0x3FF), and 4-bit threshold in bits 17:14. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on high entry register) |
| bus_addr | input | 4 | Byte address: 0x0 control, 0x4 status, 0x8 entries low, 0xC entries high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| row_drive | output | ROWS | One-hot row drive |
| col_sense | input | COLS | Column sense, high when a key on the driven row is down |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the scanner with three rows, four columns and a queue three deep. With that size, a 12-key matrix holds more keys than the eight slots, so truncation is exercised. A queue overflow takes only a handful of passes, and each pass is short (53 cycles with zero debounce), so timing, overflow and threshold cases all fit in a short run. The expected snapshot of each key pattern is computed from row and column arithmetic. Slot and gap lengths are measured on the row pins.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int ENT_W = 8;
  localparam int SLOTS = 8;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int DEB_W = 10;
  localparam int CNT_W = 11;
  localparam int NUM_W = 4;

  typedef struct packed {
    logic [SLOTS-1:0][ENT_W-1:0] ent;
    logic [NUM_W-1:0]            n;
  } snap_t;

  function automatic logic [ENT_W-1:0] make_entry(logic [ROW_W-1:0] row,
                                                  logic [COL_W-1:0] col);
    return {1'b1, row, col};
  endfunction

  function automatic logic [CNT_W-1:0] slot_cycles(logic [DEB_W-1:0] deb, int base);
    return CNT_W'(base) + CNT_W'(deb);
  endfunction

  // Append the pressed columns of one row in ascending order; extra keys drop.
  function automatic snap_t add_row(snap_t s, logic [ROW_W-1:0] row,
                                    logic [SLOTS-1:0] keys);
    snap_t r;
    r = s;
    for (int c = 0; c < SLOTS; c++) begin
      if (keys[c] && (r.n < NUM_W'(SLOTS))) begin
        r.ent[r.n[COL_W-1:0]] = make_entry(row, COL_W'(c));
        r.n = r.n + NUM_W'(1);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/kms_row_scan.sv
module kms_row_scan
  import kms_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 8,
  parameter int LEAD_CYC = 5,
  parameter int ROW_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [DEB_W-1:0]       deb,
  input  logic [COLS-1:0]        col_in,
  output logic [ROWS-1:0]        row_drive,
  output logic                   snap_push,
  output logic [SLOTS*ENT_W-1:0] snap_data
);
  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ROW} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [COLS-1:0]  ref_q;
  logic [COLS-1:0]  stab_q;
  snap_t            acc_q;
  snap_t            acc_nx;
  logic [COLS-1:0]  hits;
  logic [SLOTS-1:0] hits_w;
  logic [CNT_W-1:0] slot_len;
  logic             slot_last;
  logic             row_end;
  logic             pass_end;

  assign slot_len  = slot_cycles(deb, ROW_BASE);
  assign slot_last = (cnt_q == slot_len - CNT_W'(1));
  assign row_end   = en && (st_q == S_ROW) && slot_last;
  assign pass_end  = row_end && (row_q == ROW_W'(ROWS - 1));

  // A column counts only if it matched its first-cycle level all slot long.
  assign hits = ref_q & stab_q & ~(col_in ^ ref_q);

  always_comb begin
    hits_w = '0;
    hits_w[COLS-1:0] = hits;
  end

  assign acc_nx    = add_row(acc_q, row_q, hits_w);
  assign snap_push = pass_end && (acc_nx.n != '0);
  assign snap_data = acc_nx.ent;

  for (genvar r = 0; r < ROWS; r++) begin : g_drive
    assign row_drive[r] = (st_q == S_ROW) && (row_q == ROW_W'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      row_q  <= '0;
      ref_q  <= '0;
      stab_q <= '0;
      acc_q  <= '0;
    end else if (!en) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      row_q <= '0;
      acc_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          st_q  <= S_LEAD;
          cnt_q <= '0;
        end
        S_LEAD: begin
          if (cnt_q == CNT_W'(LEAD_CYC - 1)) begin
            st_q  <= S_ROW;
            cnt_q <= '0;
            row_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_ROW: begin
          if (cnt_q == '0) begin
            ref_q  <= col_in;
            stab_q <= '1;
          end else begin
            stab_q <= stab_q & ~(col_in ^ ref_q);
          end
          if (slot_last) begin
            cnt_q <= '0;
            acc_q <= pass_end ? '0 : acc_nx;
            if (pass_end) begin
              st_q  <= S_LEAD;
              row_q <= '0;
            end else begin
              row_q <= row_q + ROW_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kms_snap_fifo.sv
module kms_snap_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q;
  logic [PW-1:0] rp_q;
  logic          do_push;
  logic          do_pop;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop  = pop && (count != '0);
  assign do_push = push && (count != CW'(DEPTH));
  assign head    = mem[rp_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wp_q == PW'(i))) mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wp_q <= step(wp_q);
      if (do_pop)  rp_q <= step(rp_q);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kms_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 8,
  parameter int QDEPTH   = 4,
  parameter int LEAD_CYC = 5,
  parameter int ROW_BASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [ROWS-1:0] row_drive,
  input  logic [COLS-1:0] col_sense,
  output logic            irq
);
  localparam int SW = SLOTS * ENT_W;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;

  logic             ctl_en;
  logic             ctl_kp_ie;
  logic             ctl_ff_ie;
  logic [DEB_W-1:0] ctl_deb;
  logic [3:0]       ctl_thr;
  logic             st_kp;
  logic             st_ff;

  logic             aligned;
  logic [1:0]       word;
  logic             ctl_write;
  logic             st_write;
  logic             kp_clear;
  logic             ff_clear;
  logic             snap_push;
  logic             snap_pop;
  logic [SW-1:0]    snap_data;
  logic [SW-1:0]    q_head;
  logic [NUM_W-1:0] q_cnt;
  logic             kp_evt;
  logic             ff_hit;
  logic             unused_ok;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign word      = bus_addr[3:2];
  assign ctl_write = bus_wr && aligned && (word == A_CTRL);
  assign st_write  = bus_wr && aligned && (word == A_STAT);
  assign kp_clear  = st_write && bus_wdata[0];
  assign ff_clear  = st_write && bus_wdata[2];
  assign snap_pop  = bus_rd && aligned && (word == A_HI);
  assign kp_evt    = snap_push;
  assign ff_hit    = (ctl_thr != '0) && (q_cnt >= ctl_thr);
  assign unused_ok = ^bus_wdata[31:18];

  kms_row_scan #(
    .ROWS(ROWS), .COLS(COLS), .LEAD_CYC(LEAD_CYC), .ROW_BASE(ROW_BASE)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .deb(ctl_deb), .col_in(col_sense),
    .row_drive(row_drive), .snap_push(snap_push), .snap_data(snap_data)
  );

  kms_snap_fifo #(.DEPTH(QDEPTH), .W(SW), .CW(NUM_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(snap_push), .din(snap_data),
    .pop(snap_pop), .head(q_head), .count(q_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_kp_ie <= 1'b0;
      ctl_ff_ie <= 1'b0;
      ctl_deb   <= '0;
      ctl_thr   <= '0;
      st_kp     <= 1'b0;
      st_ff     <= 1'b0;
    end else begin
      if (ctl_write) begin
        ctl_en    <= bus_wdata[0];
        ctl_kp_ie <= bus_wdata[1];
        ctl_ff_ie <= bus_wdata[3];
        ctl_deb   <= bus_wdata[13:4];
        ctl_thr   <= bus_wdata[17:14];
      end
      st_kp <= (st_kp && !kp_clear) || kp_evt;
      st_ff <= (st_ff && !ff_clear) || ff_hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        A_CTRL: bus_rdata = {14'b0, ctl_thr, ctl_deb, ctl_ff_ie, 1'b0, ctl_kp_ie, ctl_en};
        A_STAT: bus_rdata = {24'b0, q_cnt, 1'b0, st_ff, 1'b0, st_kp};
        A_LO:   bus_rdata = (q_cnt != '0) ? q_head[31:0]  : 32'b0;
        A_HI:   bus_rdata = (q_cnt != '0) ? q_head[63:32] : 32'b0;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (st_kp && ctl_kp_ie) || (st_ff && ctl_ff_ie);
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int ROWS   = 16,
  parameter int QDEPTH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [ROWS-1:0] row_drive,
  input logic [3:0]      q_cnt,
  input logic            push,
  input logic            pop,
  input logic            kp_clear,
  input logic            kp_evt,
  input logic            st_kp,
  input logic            st_ff,
  input logic            ff_ie,
  input logic            irq
);
  p_one_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_drive));

  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (row_drive == '0));

  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= 4'(QDEPTH));

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == 4'(QDEPTH) && !pop) |=> (q_cnt == 4'(QDEPTH)));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && q_cnt != 4'd0) |=> (q_cnt == $past(q_cnt) - 4'd1));

  p_w1c_kp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kp_clear && !kp_evt) |=> !st_kp);

  p_irq_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ff && ff_ie) |-> irq);
endmodule

bind keymatrix_scanner kms_checker #(.ROWS(ROWS), .QDEPTH(QDEPTH)) u_kms_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .row_drive(row_drive), .q_cnt(q_cnt),
  .push(snap_push), .pop(snap_pop), .kp_clear(kp_clear), .kp_evt(kp_evt),
  .st_kp(st_kp), .st_ff(st_ff), .ff_ie(ctl_ff_ie), .irq(irq)
);

// File: tb/test_keymatrix_scanner.sv
module test_keymatrix_scanner;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int QD   = 3;
  localparam int LEAD = 5;
  localparam int BASE = 16;
  localparam int PASS0 = LEAD + ROWS * BASE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [ROWS-1:0] row_drive;
  logic [COLS-1:0] col_sense;
  wire         irq;

  logic [ROWS*COLS-1:0] keys = '0;
  logic flicker = 1'b0;
  logic flick_bit = 1'b0;
  int   fl_cnt = 0;
  int   total = 0;
  int   bad = 0;

  always_comb begin
    col_sense = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_drive[r]) col_sense = col_sense | keys[r*COLS +: COLS];
    if (row_drive[0] && flick_bit) col_sense[1] = 1'b1;
  end

  always @(negedge clk) begin
    if (flicker) begin
      fl_cnt = fl_cnt + 1;
      if (fl_cnt % 5 == 0) flick_bit = ~flick_bit;
    end else begin
      flick_bit = 1'b0;
    end
  end

  keymatrix_scanner #(.ROWS(ROWS), .COLS(COLS), .QDEPTH(QD)) i_keymatrix_scanner (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_drive(row_drive),
    .col_sense(col_sense), .irq(irq)
  );

  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_pending(int want, output int got);
    logic [31:0] s;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      bus_read(4'h4, s);
      got = int'(s[7:4]);
      if (got >= want) break;
    end
  endtask

  task automatic drain();
    logic [31:0] s;
    logic [31:0] d;
    bus_read(4'h4, s);
    while (s[7:4] != 4'd0) begin
      bus_read(4'hC, d);
      bus_read(4'h4, s);
    end
  endtask

  task automatic wait_row(int r, logic v);
    while (row_drive[r] !== v) @(negedge clk);
  endtask

  // Entry n = 0x80 + 8*row + col, row-major, first eight keys only.
  function automatic logic [63:0] expect_snap(logic [ROWS*COLS-1:0] k);
    logic [63:0] v;
    int n;
    v = '0;
    n = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (k[r*COLS + c] && n < 8) begin
          v[n*8 +: 8] = 8'(128 + r * 8 + c);
          n++;
        end
    return v;
  endfunction

  task automatic run_pattern(logic [ROWS*COLS-1:0] pat, logic [ROWS*COLS-1:0] exp_pat,
                             bit flick, string tag);
    logic [31:0] s0, s1, s2, lo, hi;
    int got;
    bus_write(4'h0, 32'h0);
    drain();
    keys = pat;
    flicker = flick;
    bus_write(4'h4, 32'h5);
    bus_write(4'h0, 32'h1);
    wait_pending(1, got);
    bus_write(4'h0, 32'h0);
    flicker = 1'b0;
    check_eq({tag, " snapshot arrived"}, 64'(got >= 1), 64'd1);
    bus_read(4'h4, s0);
    bus_read(4'h8, lo);
    bus_read(4'h4, s1);
    bus_read(4'hC, hi);
    bus_read(4'h4, s2);
    check_eq({tag, " entries"}, {hi, lo}, expect_snap(exp_pat));
    check_eq("R5 low read keeps count", 64'(s1[7:4]), 64'(s0[7:4]));
    check_eq("R5 high read pops", 64'(s2[7:4]), 64'(s0[7:4] - 4'd1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi;
    int n, got;
    logic [ROWS*COLS-1:0] p;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    bus_read(4'h0, d); check_eq("R10 reset control", 64'(d), 64'h0);
    bus_read(4'h4, d); check_eq("R7 reset status", 64'(d), 64'h0);
    check_eq("R8 reset irq", 64'(irq), 64'h0);
    check_eq("R9 reset rows idle", 64'(row_drive), 64'h0);

    // R10 field layout
    bus_write(4'h0, 32'hFFFF_FFFA);
    bus_read(4'h0, d); check_eq("R10 control readback", 64'(d), 64'h0003_FFFA);
    bus_write(4'h0, 32'h0);

    // R3 slot and gap timing
    bus_write(4'h0, 32'h1);
    wait_row(0, 1'b0); wait_row(0, 1'b1);
    n = 0;
    while (row_drive[0]) begin n++; @(negedge clk); end
    check_eq("R3 row slot debounce 0", 64'(n), 64'(BASE));
    wait_row(ROWS-1, 1'b1); wait_row(ROWS-1, 1'b0);
    n = 0;
    while (row_drive == '0) begin n++; @(negedge clk); end
    check_eq("R3 lead gap", 64'(n), 64'(LEAD));
    bus_write(4'h0, (32'd3 << 4) | 32'h1);
    wait_row(0, 1'b0); wait_row(0, 1'b1);
    wait_row(1, 1'b1);
    n = 0;
    while (row_drive[1]) begin n++; @(negedge clk); end
    check_eq("R3 row slot debounce 3", 64'(n), 64'(BASE + 3));
    bus_write(4'h0, 32'h0);

    // R1 / R2 patterns
    p = '0; p[0] = 1'b1;
    run_pattern(p, p, 1'b0, "R1 single key r0c0");
    p = '0; p[2*COLS + 3] = 1'b1;
    run_pattern(p, p, 1'b0, "R1 single key r2c3");
    p = '0; p[0*COLS + 3] = 1'b1; p[2*COLS + 1] = 1'b1;
    run_pattern(p, p, 1'b0, "R1 row order");
    p = '0; p[1*COLS +: COLS] = '1;
    run_pattern(p, p, 1'b0, "R2 full row unused slots zero");
    p = '1;
    run_pattern(p, p, 1'b0, "R2 twelve keys truncated");

    // R4 unstable column is not reported
    p = '0; p[2*COLS + 0] = 1'b1;
    run_pattern(p, p, 1'b1, "R4 flicker ignored");

    // R5 no keys, no snapshot
    bus_write(4'h0, 32'h0);
    drain();
    keys = '0;
    bus_write(4'h4, 32'h5);
    bus_write(4'h0, 32'h1);
    repeat (3 * PASS0) @(negedge clk);
    bus_read(4'h4, d);
    bus_write(4'h0, 32'h0);
    check_eq("R5 no keys no snapshot", 64'(d[7:4]), 64'h0);
    check_eq("R7 no keys flag clear", 64'(d[0]), 64'h0);

    // R6 saturation, R9 queue kept while disabled
    drain();
    p = '0; p[1*COLS + 1] = 1'b1;
    keys = p;
    bus_write(4'h0, 32'h1);
    wait_pending(QD, got);
    repeat (2 * PASS0) @(negedge clk);
    bus_write(4'h0, 32'h0);
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (row_drive != '0) n++;
      @(negedge clk);
    end
    check_eq("R9 no rows while disabled", 64'(n), 64'h0);
    bus_read(4'h4, d);
    check_eq("R6 count saturates", 64'(d[7:4]), 64'(QD));
    for (int i = 1; i <= QD; i++) begin
      bus_read(4'h8, lo);
      bus_read(4'hC, hi);
      check_eq("R6 queued snapshot", {hi, lo}, expect_snap(p));
      bus_read(4'h4, d);
      check_eq("R5 count after pop", 64'(d[7:4]), 64'(QD - i));
    end
    bus_read(4'h8, lo);
    bus_read(4'hC, hi);
    check_eq("R6 empty reads zero", {hi, lo}, 64'h0);

    // R7 / R8 threshold flag and interrupt
    p = '0; p[0*COLS + 2] = 1'b1;
    keys = p;
    bus_write(4'h4, 32'h5);
    bus_write(4'h0, (32'd2 << 14) | 32'h8 | 32'h1);
    wait_pending(1, got);
    bus_read(4'h4, d);
    check_eq("R7 below threshold", 64'(d[2]), 64'h0);
    check_eq("R8 irq low below threshold", 64'(irq), 64'h0);
    wait_pending(2, got);
    bus_write(4'h0, (32'd2 << 14) | 32'h8);
    repeat (3) @(negedge clk);
    bus_read(4'h4, d);
    check_eq("R7 threshold flag", 64'(d[2]), 64'h1);
    check_eq("R7 key found flag", 64'(d[0]), 64'h1);
    check_eq("R8 irq on threshold", 64'(irq), 64'h1);
    bus_write(4'h4, 32'h5);
    bus_read(4'h4, d);
    check_eq("R7 key flag cleared", 64'(d[0]), 64'h0);
    check_eq("R7 threshold flag resets while held", 64'(d[2]), 64'h1);
    drain();
    bus_write(4'h4, 32'h4);
    bus_read(4'h4, d);
    check_eq("R7 threshold flag cleared", 64'(d[2]), 64'h0);
    check_eq("R8 irq released", 64'(irq), 64'h0);
    bus_write(4'h0, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule